// File: doc/BRIEF.md
# Partitioned Receive Buffer Pool Manager

This block keeps track of which receive buffers are free in a buffer memory of 8 KB. The memory is split into two pools. The data pool gets three quarters of the memory and the control pool gets the remaining quarter. Writers ask a pool for a buffer and get back a buffer index. When they are done, they hand the index back. The block keeps a count of how many buffers are in use in each pool. It drives a not-ready output per pool so that the sender can be told to pause.

The buffer size is chosen by a code. A larger buffer means fewer buffers in each pool. The fill level at which each pool signals not-ready is a fraction of that pool's current capacity, chosen per pool. The control pool also signals not-ready when a separate flow-control egress FIFO (512 words deep) holds more words than a chosen watermark.

Configuration inputs are captured only on an initialise pulse. That pulse also empties both pools. The buffer memory, the overflow FIFOs and the frame writers are outside this block.

Top module: `rbp_manager`

## Requirements
- R1: The buffer size code sets the pool capacities: code 0 (64 B) gives 96 data and 32 control buffers; code 1 (128 B) gives 48 and 16; codes 2 and 3 (256 B) give 24 and 8. Capacity is reached when that many allocations succeed and the next one is refused.
- R2: A successful allocation returns the lowest-numbered free index in the range 0 to capacity-1 of that pool.
- R3: An allocation request to a pool with no free buffer raises that pool's alloc_err for one cycle. It gives no grant and leaves the in-use count unchanged.
- R4: A free request whose index is not currently allocated is rejected. This includes an index at or above the capacity. The pool raises free_err for one cycle and the count is unchanged.
- R5: Grant, error and the updated count appear in the cycle after the request, as single-cycle pulses.
- R6: The data not-ready output is high exactly when the in-use count is at or above a limit chosen by the threshold code: 0 = 1/4, 1 = 1/2, 2 = 3/4, 3 = 7/8 of the capacity. It updates on the same edge as the count.
- R7: The control not-ready output applies the same threshold rule to the control pool, using its own code.
- R8: Control not-ready is also high in the cycle after efifo_level exceeds 16 << mark code (16, 32, 64 or 128 words). A level equal to the mark does not count.
- R9: Not-ready falls in the same cycle that the count drops below the limit, or in the cycle after the level returns to the mark or below. There is no hysteresis.
- R10: The configuration inputs take effect only on an init pulse. The init pulse returns both pools to all free. Allocate and free requests in the init cycle are ignored.
- R11: After reset both pools are empty and all outputs are low. The configuration is size code 0, threshold code 0 for both pools, and mark code 0.
- R12: An allocation and a valid free to the same pool in the same cycle both take effect, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Capture configuration and empty both pools |
| cfg_buf_size | input | 2 | Buffer size code |
| cfg_data_thr | input | 2 | Data pool fill threshold code |
| cfg_ctrl_thr | input | 2 | Control pool fill threshold code |
| cfg_efifo_mark | input | 2 | Egress FIFO watermark code |
| efifo_level | input | 10 | Current egress FIFO fill in words |
| d_alloc_req | input | 1 | Data pool allocate request |
| d_free_req | input | 1 | Data pool free request |
| d_free_idx | input | 7 | Data buffer index to free |
| d_alloc_vld | output | 1 | Data allocation granted |
| d_alloc_idx | output | 7 | Granted data buffer index |
| d_alloc_err | output | 1 | Data allocation refused, pool empty |
| d_free_err | output | 1 | Data free rejected |
| d_used | output | 7 | Data buffers in use |
| d_not_ready | output | 1 | Data link-level not-ready |
| c_alloc_req | input | 1 | Control pool allocate request |
| c_free_req | input | 1 | Control pool free request |
| c_free_idx | input | 5 | Control buffer index to free |
| c_alloc_vld | output | 1 | Control allocation granted |
| c_alloc_idx | output | 5 | Granted control buffer index |
| c_alloc_err | output | 1 | Control allocation refused, pool empty |
| c_free_err | output | 1 | Control free rejected |
| c_used | output | 6 | Control buffers in use |
| c_not_ready | output | 1 | Control link-level not-ready |

## Verification
The bench builds the block with its default parameters: 8 KB of memory, a 64-byte minimum buffer and a 512-word egress FIFO. These give the full 96 and 32 buffer pools, so every buffer size code can be exercised. Each capacity is filled to exhaustion, and every threshold limit from 4 up to 84 buffers is crossed. Watermark codes 0 and 2 are probed at the mark value and one word above it.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    typedef struct packed {
        logic [1:0] bsz;
        logic [1:0] dthr;
        logic [1:0] cthr;
        logic [1:0] mark;
    } rbp_cfg_t;

    // Pool capacity for a size code; codes 2 and 3 both select the largest buffer.
    function automatic int unsigned pool_cap(int unsigned max_bufs, logic [1:0] sel);
        case (sel)
            2'd0:    return max_bufs;
            2'd1:    return max_bufs >> 1;
            default: return max_bufs >> 2;
        endcase
    endfunction

    // Fill count at which not-ready is raised.
    function automatic int unsigned fill_limit(int unsigned cap, logic [1:0] sel);
        case (sel)
            2'd0:    return cap >> 2;
            2'd1:    return cap >> 1;
            2'd2:    return cap - (cap >> 2);
            default: return cap - (cap >> 3);
        endcase
    endfunction

    function automatic int unsigned fifo_mark(int unsigned base, logic [1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/rbp_pool.sv
module rbp_pool #(
    parameter int MAX_BUFS = 96,
    localparam int IDX_W = $clog2(MAX_BUFS),
    localparam int CNT_W = $clog2(MAX_BUFS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [CNT_W-1:0] cap,
    input  logic [CNT_W-1:0] thr,
    input  logic             extra_busy,
    input  logic             alloc_req,
    input  logic             free_req,
    input  logic [IDX_W-1:0] free_idx,
    output logic             alloc_vld,
    output logic [IDX_W-1:0] alloc_idx,
    output logic             alloc_err,
    output logic             free_err,
    output logic [CNT_W-1:0] used,
    output logic             not_ready
);

    typedef struct packed {
        logic [MAX_BUFS-1:0] busy;
        logic [CNT_W-1:0]    used;
        logic                vld;
        logic [IDX_W-1:0]    idx;
        logic                aerr;
        logic                ferr;
        logic                nr;
    } pool_st_t;

    pool_st_t st_d, st_q;
    logic             found;
    logic [IDX_W-1:0] pick;
    logic             alloc_ok;
    logic             free_ok;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.aerr = 1'b0;
        st_d.ferr = 1'b0;

        // lowest free index below the active capacity
        found = 1'b0;
        pick  = '0;
        for (int i = MAX_BUFS - 1; i >= 0; i--) begin
            if (!st_q.busy[i] && (CNT_W'(i) < cap)) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end

        alloc_ok = 1'b0;
        free_ok  = 1'b0;

        if (init) begin
            st_d.busy = '0;
            st_d.used = '0;
        end else begin
            alloc_ok = alloc_req && found;
            free_ok  = free_req && (CNT_W'(free_idx) < cap) && st_q.busy[free_idx];
            if (alloc_ok) begin
                st_d.busy[pick] = 1'b1;
                st_d.vld        = 1'b1;
                st_d.idx        = pick;
            end
            st_d.aerr = alloc_req && !found;
            if (free_ok) begin
                st_d.busy[free_idx] = 1'b0;
            end
            st_d.ferr = free_req && !free_ok;
            if (alloc_ok && !free_ok) begin
                st_d.used = st_q.used + CNT_W'(1);
            end else if (!alloc_ok && free_ok) begin
                st_d.used = st_q.used - CNT_W'(1);
            end
        end

        st_d.nr = (st_d.used >= thr) || extra_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_vld = st_q.vld;
    assign alloc_idx = st_q.idx;
    assign alloc_err = st_q.aerr;
    assign free_err  = st_q.ferr;
    assign used      = st_q.used;
    assign not_ready = st_q.nr;

endmodule

// File: rtl/rbp_manager.sv
module rbp_manager #(
    parameter int MEM_BYTES     = 8192,
    parameter int MIN_BUF_BYTES = 64,
    parameter int EFIFO_WORDS   = 512,
    parameter int MARK_BASE     = 16,
    localparam int TOTAL_BUFS   = MEM_BYTES / MIN_BUF_BYTES,
    localparam int D_MAX        = (TOTAL_BUFS * 3) / 4,
    localparam int C_MAX        = TOTAL_BUFS - D_MAX,
    localparam int DI_W         = $clog2(D_MAX),
    localparam int DC_W         = $clog2(D_MAX + 1),
    localparam int CI_W         = $clog2(C_MAX),
    localparam int CC_W         = $clog2(C_MAX + 1),
    localparam int EF_W         = $clog2(EFIFO_WORDS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic [1:0]      cfg_buf_size,
    input  logic [1:0]      cfg_data_thr,
    input  logic [1:0]      cfg_ctrl_thr,
    input  logic [1:0]      cfg_efifo_mark,
    input  logic [EF_W-1:0] efifo_level,
    input  logic            d_alloc_req,
    input  logic            d_free_req,
    input  logic [DI_W-1:0] d_free_idx,
    output logic            d_alloc_vld,
    output logic [DI_W-1:0] d_alloc_idx,
    output logic            d_alloc_err,
    output logic            d_free_err,
    output logic [DC_W-1:0] d_used,
    output logic            d_not_ready,
    input  logic            c_alloc_req,
    input  logic            c_free_req,
    input  logic [CI_W-1:0] c_free_idx,
    output logic            c_alloc_vld,
    output logic [CI_W-1:0] c_alloc_idx,
    output logic            c_alloc_err,
    output logic            c_free_err,
    output logic [CC_W-1:0] c_used,
    output logic            c_not_ready
);
    import rbp_pkg::*;

    rbp_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (init) begin
            cfg_d.bsz  = cfg_buf_size;
            cfg_d.dthr = cfg_data_thr;
            cfg_d.cthr = cfg_ctrl_thr;
            cfg_d.mark = cfg_efifo_mark;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [DC_W-1:0] d_cap, d_thr;
    logic [CC_W-1:0] c_cap, c_thr;
    logic [EF_W-1:0] c_mark;
    logic            c_over;

    assign d_cap  = DC_W'(pool_cap(D_MAX, cfg_q.bsz));
    assign c_cap  = CC_W'(pool_cap(C_MAX, cfg_q.bsz));
    assign d_thr  = DC_W'(fill_limit(int'(d_cap), cfg_q.dthr));
    assign c_thr  = CC_W'(fill_limit(int'(c_cap), cfg_q.cthr));
    assign c_mark = EF_W'(fifo_mark(MARK_BASE, cfg_q.mark));
    assign c_over = efifo_level > c_mark;

    rbp_pool #(.MAX_BUFS(D_MAX)) u_data_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .cap        (d_cap),
        .thr        (d_thr),
        .extra_busy (1'b0),
        .alloc_req  (d_alloc_req),
        .free_req   (d_free_req),
        .free_idx   (d_free_idx),
        .alloc_vld  (d_alloc_vld),
        .alloc_idx  (d_alloc_idx),
        .alloc_err  (d_alloc_err),
        .free_err   (d_free_err),
        .used       (d_used),
        .not_ready  (d_not_ready)
    );

    rbp_pool #(.MAX_BUFS(C_MAX)) u_ctrl_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .cap        (c_cap),
        .thr        (c_thr),
        .extra_busy (c_over),
        .alloc_req  (c_alloc_req),
        .free_req   (c_free_req),
        .free_idx   (c_free_idx),
        .alloc_vld  (c_alloc_vld),
        .alloc_idx  (c_alloc_idx),
        .alloc_err  (c_alloc_err),
        .free_err   (c_free_err),
        .used       (c_used),
        .not_ready  (c_not_ready)
    );

endmodule

// File: rtl/rbp_manager_chk.sv
module rbp_manager_chk #(
    parameter int DI_W = 7,
    parameter int DC_W = 7,
    parameter int CC_W = 6,
    parameter int EF_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init,
    input logic [EF_W-1:0] efifo_level,
    input logic            d_alloc_req,
    input logic            d_free_req,
    input logic            d_alloc_vld,
    input logic [DI_W-1:0] d_alloc_idx,
    input logic            d_alloc_err,
    input logic            d_free_err,
    input logic [DC_W-1:0] d_used,
    input logic            d_not_ready,
    input logic            c_alloc_vld,
    input logic            c_alloc_err,
    input logic [CC_W-1:0] c_used,
    input logic            c_not_ready,
    input logic [DC_W-1:0] d_cap,
    input logic [DC_W-1:0] d_thr,
    input logic [CC_W-1:0] c_cap,
    input logic [CC_W-1:0] c_thr,
    input logic [EF_W-1:0] c_mark
);

    AST_GRANT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        d_alloc_vld |-> ($past(d_alloc_req) && !$past(init))); // R5

    AST_IDX_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        d_alloc_vld |-> (d_alloc_idx < DI_W'(d_cap))); // R2

    AST_DATA_ERR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        d_alloc_err |-> ($past(d_used) == $past(d_cap))); // R3

    AST_CTRL_ERR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        c_alloc_err |-> ($past(c_used) == $past(c_cap))); // R3

    AST_INIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init) |-> (d_used == '0 && c_used == '0 && !d_alloc_vld && !c_alloc_vld)); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(init) |-> (int'(d_used) == int'($past(d_used)) + int'(d_alloc_vld)
                          - int'($past(d_free_req) && !d_free_err))); // R12

    AST_DATA_NR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        d_not_ready == (d_used >= d_thr)); // R6

    AST_CTRL_NR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        c_not_ready |-> ((c_used >= c_thr) || $past(efifo_level > c_mark))); // R8

    AST_CTRL_NR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_used < c_thr) && !$past(efifo_level > c_mark)) |-> !c_not_ready); // R9

endmodule

bind rbp_manager rbp_manager_chk #(
    .DI_W(DI_W), .DC_W(DC_W), .CC_W(CC_W), .EF_W(EF_W)
) u_chk (.*);

// File: tb/sim_rbp_manager.sv
module sim_rbp_manager;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init = 1'b0;
    logic [1:0] cfg_buf_size = '0, cfg_data_thr = '0, cfg_ctrl_thr = '0, cfg_efifo_mark = '0;
    logic [9:0] efifo_level = '0;
    logic       d_alloc_req = 1'b0, d_free_req = 1'b0;
    logic [6:0] d_free_idx = '0;
    logic       c_alloc_req = 1'b0, c_free_req = 1'b0;
    logic [4:0] c_free_idx = '0;
    logic       d_alloc_vld, d_alloc_err, d_free_err, d_not_ready;
    logic [6:0] d_alloc_idx, d_used;
    logic       c_alloc_vld, c_alloc_err, c_free_err, c_not_ready;
    logic [4:0] c_alloc_idx;
    logic [5:0] c_used;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rbp_manager u0 (.*);

    // {size, dthr code, cthr code, data cap, ctrl cap, data limit, ctrl limit}
    localparam logic [31:0] VECS [5] = '{
        {2'd0, 2'd3, 2'd1, 7'd96, 6'd32, 7'd84, 6'd16},
        {2'd1, 2'd2, 2'd0, 7'd48, 6'd16, 7'd36, 6'd4},
        {2'd2, 2'd0, 2'd3, 7'd24, 6'd8,  7'd6,  6'd7},
        {2'd3, 2'd1, 2'd2, 7'd24, 6'd8,  7'd12, 6'd6},
        {2'd1, 2'd3, 2'd3, 7'd48, 6'd16, 7'd42, 6'd14}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of requests starting at a falling edge; return at the next falling edge.
    task automatic drive(input bit ini, input bit da, input bit df, input int dfi,
                         input bit ca, input bit cf, input int cfi);
        init = ini; d_alloc_req = da; d_free_req = df; d_free_idx = 7'(dfi);
        c_alloc_req = ca; c_free_req = cf; c_free_idx = 5'(cfi);
        @(negedge clk);
        init = 1'b0; d_alloc_req = 1'b0; d_free_req = 1'b0;
        c_alloc_req = 1'b0; c_free_req = 1'b0;
    endtask

    task automatic do_init(input logic [1:0] bsz, input logic [1:0] dt,
                           input logic [1:0] ct, input logic [1:0] mk);
        cfg_buf_size = bsz; cfg_data_thr = dt; cfg_ctrl_thr = ct; cfg_efifo_mark = mk;
        drive(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk(d_used == 0 && c_used == 0, "R11 counts", int'(d_used) + int'(c_used), 0);
        chk(!d_not_ready && !c_not_ready && !d_alloc_vld && !c_alloc_vld && !d_alloc_err,
            "R11 outputs", int'(d_not_ready) + int'(c_not_ready), 0);
        // R11: default is 96 buffers with limit 24
        for (int k = 0; k < 24; k++) drive(0, 1, 0, 0, 0, 0, 0);
        chk(d_used == 24 && d_not_ready, "R11 default limit", int'(d_not_ready), 1);

        // Table walk: R1 R2 R3 R6 R7
        for (int v = 0; v < 5; v++) begin
            automatic logic [31:0] e = VECS[v];
            automatic int dcap = int'(e[25:19]);
            automatic int ccap = int'(e[18:13]);
            automatic int dlim = int'(e[12:6]);
            automatic int clim = int'(e[5:0]);
            do_init(e[31:30], e[29:28], e[27:26], 2'd0);
            chk(d_used == 0 && c_used == 0, "R10 init empties", int'(d_used), 0);
            for (int k = 0; k < dcap; k++) begin
                drive(0, 1, 0, 0, 0, 0, 0);
                chk(d_alloc_vld && d_alloc_idx == 7'(k), "R2 data index", int'(d_alloc_idx), k);
                chk(d_used == 7'(k + 1), "R1 data count", int'(d_used), k + 1);
                chk(d_not_ready == (k + 1 >= dlim), "R6 data not-ready", int'(d_not_ready),
                    int'(k + 1 >= dlim));
            end
            drive(0, 1, 0, 0, 0, 0, 0);
            chk(d_alloc_err && !d_alloc_vld, "R3 data empty refuse", int'(d_alloc_err), 1);
            chk(d_used == 7'(dcap), "R1 data capacity", int'(d_used), dcap);
            for (int k = 0; k < ccap; k++) begin
                drive(0, 0, 0, 0, 1, 0, 0);
                chk(c_alloc_vld && c_alloc_idx == 5'(k), "R2 ctrl index", int'(c_alloc_idx), k);
                chk(c_not_ready == (k + 1 >= clim), "R7 ctrl not-ready", int'(c_not_ready),
                    int'(k + 1 >= clim));
            end
            drive(0, 0, 0, 0, 1, 0, 0);
            chk(c_alloc_err && !c_alloc_vld, "R3 ctrl empty refuse", int'(c_alloc_err), 1);
            chk(c_used == 6'(ccap), "R1 ctrl capacity", int'(c_used), ccap);
        end

        // 48 data buffers, data limit 24, ctrl limit 14, mark 16
        do_init(2'd1, 2'd1, 2'd3, 2'd0);
        for (int k = 0; k < 24; k++) drive(0, 1, 0, 0, 0, 0, 0);
        chk(d_not_ready, "R6 at limit", int'(d_not_ready), 1);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(!d_alloc_vld, "R5 single-cycle grant", int'(d_alloc_vld), 0);
        drive(0, 0, 1, 5, 0, 0, 0);
        chk(!d_free_err && d_used == 23, "R4 valid free", int'(d_used), 23);
        chk(!d_not_ready, "R9 data release", int'(d_not_ready), 0);
        drive(0, 0, 1, 5, 0, 0, 0);
        chk(d_free_err && d_used == 23, "R4 double free", int'(d_free_err), 1);
        drive(0, 0, 1, 50, 0, 0, 0);
        chk(d_free_err && d_used == 23, "R4 out of range free", int'(d_free_err), 1);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(!d_free_err, "R5 error pulse ends", int'(d_free_err), 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        chk(d_alloc_vld && d_alloc_idx == 5, "R2 reuse lowest", int'(d_alloc_idx), 5);
        drive(0, 1, 1, 0, 0, 0, 0);
        chk(d_alloc_vld && d_alloc_idx == 24 && !d_free_err, "R12 same-cycle idx",
            int'(d_alloc_idx), 24);
        chk(d_used == 24, "R12 same-cycle count", int'(d_used), 24);
        drive(0, 0, 0, 0, 1, 1, 3);
        chk(c_alloc_vld && c_free_err && c_used == 1, "R4 ctrl bad free", int'(c_used), 1);

        // Watermark 16 on control not-ready
        efifo_level = 10'd16;
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(!c_not_ready, "R8 level at mark", int'(c_not_ready), 0);
        efifo_level = 10'd17;
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(c_not_ready, "R8 level above mark", int'(c_not_ready), 1);
        efifo_level = 10'd0;
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(!c_not_ready, "R9 watermark release", int'(c_not_ready), 0);

        do_init(2'd1, 2'd1, 2'd3, 2'd2);
        efifo_level = 10'd64;
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(!c_not_ready, "R8 mark 64 equal", int'(c_not_ready), 0);
        efifo_level = 10'd65;
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(c_not_ready, "R8 mark 64 exceeded", int'(c_not_ready), 1);
        efifo_level = 10'd0;
        drive(0, 0, 0, 0, 0, 0, 0);

        // R10: config change without init has no effect (ctrl cap stays 16)
        cfg_buf_size = 2'd0;
        for (int k = 0; k < 16; k++) drive(0, 0, 0, 0, 1, 0, 0);
        chk(c_used == 16, "R10 cap unchanged", int'(c_used), 16);
        drive(0, 0, 0, 0, 1, 0, 0);
        chk(c_alloc_err && c_used == 16, "R10 no reconfig", int'(c_alloc_err), 1);

        // R10: requests in init cycle ignored
        drive(1, 1, 0, 0, 1, 0, 0);
        chk(d_used == 0 && c_used == 0 && !d_alloc_vld && !c_alloc_vld,
            "R10 init ignores requests", int'(d_used) + int'(c_used), 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        chk(d_alloc_vld && d_alloc_idx == 0 && d_used == 1, "R1 first after init",
            int'(d_alloc_idx), 0);

        finish_run();
    end

endmodule